// File: doc/BRIEF.md
# Multi-lane pixel word serializer

This block turns one 27-bit parallel pixel word per pixel period into a 30-bit serial frame. The word holds 24 colour bits and 3 control bits. The block adds an odd-parity bit and two zero reserved bits, then sends the frame over one, two or three data lanes. A two-bit lane select picks the lane count, and a further lane carries a recreated pixel clock. Everything runs on one fast bit clock. A one-cycle pixel strobe marks the start of each pixel period, so the strobe repeats every 30, 15 or 10 bit-clock cycles.

The block manages its own power state. It drops into standby when the strobe stops arriving. It goes into shutdown while its enable input is low. Before it transmits again it needs two strobes in a row.

Top module: `pxser_top`

## Requirements
- R1: After reset, `powerState` is 01 (standby) and all data lanes and the clock lane are 0.
- R2: Word bits [26:3] are colour and bits [2:0] are control. Frame bit i (i = 0..26) equals `pixWord[26-i]`, so colour goes out MSB first and the control bits follow. Frame bit 27 is parity and frame bits 28 and 29 are 0.
- R3: The parity bit is chosen so that the 27 word bits plus parity hold an odd number of ones.
- R4: `linkSel` 00 selects 1 lane (30 slots per period), 01 selects 2 lanes (15 slots) and 10 selects 3 lanes (10 slots). Frame bit i appears on `laneOut[i mod N]` in slot i div N. Slot 0 is visible in the cycle after the clock edge that samples the strobe, and each later slot follows one cycle after the one before.
- R5: `linkSel` 11 behaves exactly like 10 (three lanes).
- R6: Lanes with an index of N or above stay 0 while transmitting.
- R7: `clkLane` is 1 for the first ceil(S/2) slots of each period and 0 for the remaining slots, where S is the number of slots (for S = 15 it is high for 8 slots).
- R8: If no strobe has been sampled for 64 consecutive bit-clock edges, the block moves from active (11) or waking (10) to standby (01) on that 64th edge, and all lanes go to 0.
- R9: While `txEnable` is low, `powerState` is 00 (shutdown) from the next edge on, all lanes are 0 and strobes are ignored. When `txEnable` goes high again, the block goes to standby.
- R10: From standby, the first strobe moves the block to waking (10) and nothing is sent. The second strobe moves it to active (11), and the word sampled with that second strobe is sent as a complete frame.
- R11: After the last slot of a frame, if no new strobe has arrived, the data lanes and the clock lane are 0 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixStrobe | input | 1 | One-cycle marker at the start of each pixel period |
| pixWord | input | 27 | Colour bits [26:3] and control bits [2:0] |
| linkSel | input | 2 | Lane count select |
| txEnable | input | 1 | Low forces shutdown |
| laneOut | output | 3 | Serial data lanes |
| clkLane | output | 1 | Recreated pixel clock lane |
| powerState | output | 2 | 00 shutdown, 01 standby, 10 waking, 11 active |

## Verification
A word sampled by a strobe at edge t shows its slot s on the lanes in the cycle after edge t+s. The bench drives each strobe half a cycle before its sampling edge and then compares one slot at every following falling edge. It places the next strobe in the last slot's sampling cycle, so that periods run back to back.

The loss timeout lands on edge t+64 after the last strobe. The bench checks the state once after edge t+63, where the block must still be active, and once after edge t+64, where it must be in standby.

Changes to the enable are due one edge after they are applied, and the bench checks them at the next falling edge.

// File: rtl/pxser_pkg.sv
package pxser_pkg;
  localparam int WORD_BITS  = 27;
  localparam int FRAME_BITS = 30;
  localparam int PAR_POS    = WORD_BITS;
  localparam int MAX_LANES  = 3;
  localparam int SLOT_W     = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(FRAME_BITS) + 1;

  typedef enum logic [1:0] {
    PS_OFF  = 2'b00,
    PS_IDLE = 2'b01,
    PS_WAKE = 2'b10,
    PS_RUN  = 2'b11
  } pwr_e;

  typedef struct packed {
    logic              load;
    logic              txOn;
    logic              clkPhase;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        lanes;
  } dpCtrl_t;
endpackage

// File: rtl/pxser_ctrl.sv
module pxser_ctrl
  import pxser_pkg::*;
#(
  parameter int LossLimit = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixStrobe,
  input  logic [1:0] linkSel,
  input  logic       txEnable,
  output dpCtrl_t    dpCtrl,
  output pwr_e       pwrState
);
  localparam int CNT_W = $clog2(LossLimit + 1);

  pwr_e              state, stateNx;
  logic [CNT_W-1:0]  idleCnt;
  logic              lossNow;
  logic              load;
  logic [SLOT_W-1:0] slot, slotsPer, halfSlots;
  logic [1:0]        lanes, laneReq;
  logic              sending;

  assign lossNow = !pixStrobe && (idleCnt == CNT_W'(LossLimit - 1));
  assign load    = txEnable && pixStrobe && (state == PS_WAKE || state == PS_RUN);

  always_comb begin
    case (linkSel)
      2'b00:   laneReq = 2'd1;
      2'b01:   laneReq = 2'd2;
      default: laneReq = 2'd3;
    endcase
  end

  always_comb begin
    case (lanes)
      2'd1:    slotsPer = SLOT_W'(FRAME_BITS);
      2'd2:    slotsPer = SLOT_W'(FRAME_BITS / 2);
      default: slotsPer = SLOT_W'(FRAME_BITS / 3);
    endcase
    halfSlots = (slotsPer + SLOT_W'(1)) >> 1;
  end

  always_comb begin
    stateNx = state;
    if (!txEnable) stateNx = PS_OFF;
    else begin
      case (state)
        PS_OFF:  stateNx = PS_IDLE;
        PS_IDLE: if (pixStrobe) stateNx = PS_WAKE;
        PS_WAKE: if (pixStrobe) stateNx = PS_RUN;
                 else if (lossNow) stateNx = PS_IDLE;
        PS_RUN:  if (lossNow) stateNx = PS_IDLE;
        default: stateNx = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PS_IDLE;
      idleCnt <= '0;
    end else begin
      state <= stateNx;
      if (pixStrobe) idleCnt <= '0;
      else if (idleCnt != CNT_W'(LossLimit - 1)) idleCnt <= idleCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot    <= '0;
      sending <= 1'b0;
      lanes   <= 2'd1;
    end else if (load) begin
      slot    <= '0;
      sending <= 1'b1;
      lanes   <= laneReq;
    end else if (stateNx != PS_RUN) begin
      sending <= 1'b0;
    end else if (sending) begin
      if (slot == slotsPer - SLOT_W'(1)) sending <= 1'b0;
      else slot <= slot + SLOT_W'(1);
    end
  end

  always_comb begin
    dpCtrl.load     = load;
    dpCtrl.txOn     = sending;
    dpCtrl.clkPhase = sending && (slot < halfSlots);
    dpCtrl.slot     = slot;
    dpCtrl.lanes    = lanes;
  end

  assign pwrState = state;
endmodule

// File: rtl/pxser_dp.sv
module pxser_dp
  import pxser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              dpCtrl,
  input  logic [WORD_BITS-1:0] pixWord,
  output logic [MAX_LANES-1:0] laneOut,
  output logic                 clkLane
);
  logic [FRAME_BITS-1:0] frame, frameNx;

  for (genvar i = 0; i < WORD_BITS; i++) begin : g_order
    assign frameNx[i] = pixWord[WORD_BITS-1-i];
  end
  assign frameNx[PAR_POS] = ~^pixWord;
  assign frameNx[FRAME_BITS-1:PAR_POS+1] = '0;

  always_ff @(posedge clk) begin
    if (!rstN) frame <= '0;
    else if (dpCtrl.load) frame <= frameNx;
  end

  for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
    logic [IDX_W-1:0] bitIdx;
    assign bitIdx = IDX_W'(dpCtrl.slot) * IDX_W'(dpCtrl.lanes) + IDX_W'(k);
    assign laneOut[k] = dpCtrl.txOn && (dpCtrl.lanes > 2'(k)) &&
                        (bitIdx < IDX_W'(FRAME_BITS)) && frame[bitIdx[IDX_W-2:0]];
  end

  assign clkLane = dpCtrl.clkPhase;
endmodule

// File: rtl/pxser_top.sv
module pxser_top
  import pxser_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixStrobe,
  input  logic [26:0] pixWord,
  input  logic [1:0]  linkSel,
  input  logic        txEnable,
  output logic [2:0]  laneOut,
  output logic        clkLane,
  output logic [1:0]  powerState
);
  dpCtrl_t dpCtrl;
  pwr_e    pwrState;

  pxser_ctrl #(.LossLimit(64)) i_ctrl (
    .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe), .linkSel(linkSel),
    .txEnable(txEnable), .dpCtrl(dpCtrl), .pwrState(pwrState)
  );

  pxser_dp i_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .pixWord(pixWord),
    .laneOut(laneOut), .clkLane(clkLane)
  );

  assign powerState = pwrState;
endmodule

// File: rtl/pxser_chk.sv
module pxser_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pixStrobe,
  input logic       txEnable,
  input logic [2:0] laneOut,
  input logic       clkLane,
  input logic [1:0] powerState
);
  logic [6:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= '0;
    else if (pixStrobe) gapCnt <= '0;
    else if (gapCnt != 7'd64) gapCnt <= gapCnt + 7'd1;
  end

  // R9
  shutdown_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> powerState == 2'b00);

  // R9
  quiet_unless_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerState != 2'b11 |-> (laneOut == 3'b000 && !clkLane));

  // R10
  no_direct_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerState == 2'b01 |=> powerState != 2'b11);

  // R8
  strobe_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt == 7'd64 |-> powerState != 2'b11);
endmodule

bind pxser_top pxser_chk i_chk (
  .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe), .txEnable(txEnable),
  .laneOut(laneOut), .clkLane(clkLane), .powerState(powerState)
);

// File: tb/test_pxser_top.sv
module test_pxser_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixStrobe = 1'b0;
  logic [26:0] pixWord = '0;
  logic [1:0]  linkSel = 2'b00;
  logic        txEnable = 1'b1;
  logic [2:0]  laneOut;
  logic        clkLane;
  logic [1:0]  powerState;
  int checks = 0;
  int errors = 0;

  localparam logic [28:0] VEC [8] = '{
    {2'b00, 27'h0000000}, {2'b00, 27'h7FFFFFF},
    {2'b01, 27'h5A5A5A5}, {2'b01, 27'h0000001},
    {2'b10, 27'h4000000}, {2'b10, 27'h1234567},
    {2'b11, 27'h2C0FFEE}, {2'b11, 27'h6DB6DB6}
  };

  always #4 clk = ~clk;

  pxser_top i_pxser_top (
    .clk(clk), .rstN(rstN), .pixStrobe(pixStrobe), .pixWord(pixWord),
    .linkSel(linkSel), .txEnable(txEnable), .laneOut(laneOut),
    .clkLane(clkLane), .powerState(powerState)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [29:0] expFrame(input logic [26:0] w);
    logic [29:0] f;
    int ones;
    f = '0;
    ones = 0;
    for (int i = 0; i < 27; i++) begin
      f[i] = w[26-i];
      ones += int'(w[i]);
    end
    f[27] = (ones % 2 == 0);
    return f;
  endfunction

  task automatic sendPix(input logic [26:0] w, input logic [1:0] sel, input bit expTx);
    int n, nSlots;
    logic [29:0] f;
    logic [2:0] el;
    logic ec;
    string tag;
    n = (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 3;
    nSlots = 30 / n;
    f = expFrame(w);
    tag = (sel == 2'b11) ? "R5 R2 R3 R6" : "R4 R2 R3 R6";
    pixWord = w;
    linkSel = sel;
    pixStrobe = 1'b1;
    for (int s = 0; s < nSlots; s++) begin
      @(negedge clk);
      pixStrobe = 1'b0;
      el = '0;
      for (int k = 0; k < n; k++) if (expTx) el[k] = f[s*n+k];
      ec = expTx && (s < (nSlots + 1) / 2);
      check(laneOut == el, expTx ? tag : "R10", int'(laneOut), int'(el));
      check(clkLane == ec, "R7", int'(clkLane), int'(ec));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lastSlots;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    check(powerState == 2'b01, "R1", int'(powerState), 1);
    check(laneOut == 3'b000 && !clkLane, "R1", int'({clkLane, laneOut}), 0);

    // R10: first strobe only arms
    sendPix(27'h1555555, 2'b00, 1'b0);
    check(powerState == 2'b10, "R10", int'(powerState), 2);

    lastSlots = 30;
    foreach (VEC[v]) begin
      sendPix(VEC[v][26:0], VEC[v][28:27], 1'b1);
      check(powerState == 2'b11, "R10", int'(powerState), 3);
      lastSlots = 30 / ((VEC[v][28:27] == 2'b00) ? 1 : (VEC[v][28:27] == 2'b01) ? 2 : 3);
    end

    // R11: frame ended, no strobe
    @(negedge clk);
    check(laneOut == 3'b000 && !clkLane, "R11", int'({clkLane, laneOut}), 0);
    check(powerState == 2'b11, "R11", int'(powerState), 3);
    // R8: still active after edge t+63, standby after t+64
    repeat (63 - lastSlots) @(negedge clk);
    check(powerState == 2'b11, "R8", int'(powerState), 3);
    @(negedge clk);
    check(powerState == 2'b01, "R8", int'(powerState), 1);
    check(laneOut == 3'b000, "R8", int'(laneOut), 0);

    // R9: shutdown
    sendPix(27'h0ABCDEF, 2'b01, 1'b0);
    sendPix(27'h3333333, 2'b01, 1'b1);
    txEnable = 1'b0;
    pixStrobe = 1'b1;
    @(negedge clk);
    check(powerState == 2'b00, "R9", int'(powerState), 0);
    check(laneOut == 3'b000 && !clkLane, "R9", int'({clkLane, laneOut}), 0);
    repeat (5) @(negedge clk);
    check(powerState == 2'b00, "R9", int'(powerState), 0);
    check(laneOut == 3'b000, "R9", int'(laneOut), 0);
    pixStrobe = 1'b0;
    txEnable = 1'b1;
    @(negedge clk);
    check(powerState == 2'b01, "R9", int'(powerState), 1);

    // R10: wake again in two-lane mode
    sendPix(27'h7000001, 2'b01, 1'b0);
    check(powerState == 2'b10, "R10", int'(powerState), 2);
    sendPix(27'h0F0F0F0, 2'b01, 1'b1);
    check(powerState == 2'b11, "R10", int'(powerState), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule